// File: doc/BRIEF.md
# System Clock Change Controller

This block manages the system clock of a small microcontroller. Software programs an 8-bit control register through a simple write/read port. The register holds four settings. The first is a pending clock rate, which is either a power-of-two fraction of the main clock or half of a slow sub-clock. The second is a flag that permits the rate to change. The third is a request to stop the main oscillator. The fourth is the warm-up length used after leaving the STOP state. The pending rate is not applied when it is written. It is copied into the active divider only when a STOP request arrives while the change flag is set. This means software reconfigures the clock by arming the register and then entering STOP.

When a wake-up event releases STOP, a warm-up counter runs for a programmable number of main-clock periods. The selectable lengths are 2^18, 2^17, 2^16 or 2^15 periods at the default setting, which is roughly 26 ms down to 3.3 ms at 10 MHz. During the warm-up count, the ready flag stays low and no system clock enable is issued. The main clock is the block's own clock `clk`. The sub-clock arrives as a one-cycle strobe. The divided system clock leaves the block as a single-cycle enable pulse.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x00, `ready` is 1, `sys_en` is 0 and `main_osc_en` is 1.
- R2: A write updates the register on the next clock edge and `rd_data` shows it. Bit 2 is reserved and always reads 0; a 1 written there is dropped.
- R3: If a write carries the reserved rate code 101 or 110 in bits 5:3, the previous value of bits 5:3 is kept. All other bits of that write are still stored.
- R4: While running from the main clock, `sys_en` pulses for one cycle every N cycles. N is 32, 16, 8, 4 or 2 for rate codes 000, 001, 010, 011 and 100.
- R5: With active rate code 111, `sys_en` pulses only in a cycle where `sub_tick` is high, on every second `sub_tick`. The count of sub-clock strobes restarts when running resumes.
- R6: A one-cycle `stop_req` while running moves the block to STOP. The pending rate in bits 5:3 becomes active only if bit 7 is 1 at that moment; otherwise the old divider stays in use.
- R7: In STOP and in warm-up, `ready` and `sys_en` are 0. A `wake_evt` pulse while running has no effect.
- R8: Let the wake edge be the clock edge on which `wake_evt` is seen in STOP. `ready` rises L cycles after that edge, where L = 2^(WU_BASE+3-c) and c is bits 1:0. With WU_BASE = 15, this gives L = 2^18, 2^17, 2^16 and 2^15 for c = 00, 01, 10 and 11.
- R9: A `stop_req` during warm-up is ignored, and warm-up ends on schedule.
- R10: The divider restarts from zero whenever running resumes. For a main rate of N, the first `sys_en` pulse comes N-1 cycles after the first cycle in which `ready` is high.
- R11: `main_osc_en` is 0 exactly when bit 6 is 1 and the active rate code is 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| sub_tick | input | 1 | One-cycle strobe per sub-clock period |
| stop_req | input | 1 | Enter STOP (one-cycle pulse) |
| wake_evt | input | 1 | Leave STOP (one-cycle pulse) |
| sys_en | output | 1 | System clock enable pulse |
| ready | output | 1 | High while the system clock runs |
| main_osc_en | output | 1 | Main oscillator enable |

## Verification
All inputs are driven, and all outputs are sampled, 1 ns after a falling edge. A register write therefore appears on `rd_data` at the next sample. `ready` falls at the sample right after `stop_req`. After `wake_evt`, `ready` is first seen high at the (L+1)th sample, which is one more than L because the wake edge itself follows the sample where the pulse was driven. The first `sys_en` comes N-1 samples after `ready` is seen, and later pulses come exactly N samples apart. The bench counts samples against these figures. The warm-up base is shortened to 4 so that every code can be run.

// File: rtl/sysclk_pkg.sv
// Shared types and helpers for the system clock change controller.
// Assumes: rate code 111 selects the sub-clock; 101 and 110 are unused.
package sysclk_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WARM = 2'd2
    } sc_state_e;

    localparam logic [2:0] SEL_SUB = 3'b111;

    // True for a rate code that may be stored
    function automatic logic sel_legal(input logic [2:0] s);
        return !(s == 3'b101 || s == 3'b110);
    endfunction

endpackage

// File: rtl/sc_ctrl_reg.sv
// Control register: masks the reserved bit and keeps the old rate field
// when a reserved rate code is written. Assumes a one-cycle write strobe.
module sc_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] ctrl_q
);
    import sysclk_pkg::*;

    logic [2:0] sel_next;

    // Pick the rate field to store
    always_comb begin
        sel_next = sel_legal(wr_data[5:3]) ? wr_data[5:3] : ctrl_q[5:3];
    end

    // Register update on write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= 8'h00;
        else if (wr_en)
            ctrl_q <= {wr_data[7:6], sel_next, 1'b0, wr_data[1:0]};
    end

    p_wr_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q[7:6] == $past(wr_data[7:6]) && ctrl_q[1:0] == $past(wr_data[1:0])));

    p_reserved_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q[2] == 1'b0));

    p_sel_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_legal(wr_data[5:3])) |=> $stable(ctrl_q[5:3]));

endmodule

// File: rtl/sc_warmup.sv
// STOP / warm-up sequencer. stop_req while running enters STOP and
// commits the rate when enabled. wake_evt in STOP starts a warm-up of
// 2^(WU_BASE+3-code) main-clock cycles, then running resumes.
module sc_warmup #(
    parameter int WU_BASE = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stop_req,
    input  logic                  wake_evt,
    input  logic                  chg_en,
    input  logic [1:0]            wu_code,
    output sysclk_pkg::sc_state_e state,
    output logic                  commit,
    output logic                  ready
);
    import sysclk_pkg::*;

    localparam int WCW = WU_BASE + 4;

    logic [WCW-1:0] wcnt;
    logic [WCW-1:0] term;

    // Terminal count for the selected warm-up length
    always_comb begin
        term = WCW'((1 << (WU_BASE + 3 - int'(wu_code))) - 1);
    end

    // Commit strobe and ready flag
    always_comb begin
        commit = (state == ST_RUN) && stop_req && chg_en;
        ready  = (state == ST_RUN);
    end

    // State and warm-up counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            wcnt  <= '0;
        end else begin
            case (state)
                ST_RUN:  if (stop_req) state <= ST_STOP;
                ST_STOP: if (wake_evt) begin
                    state <= ST_WARM;
                    wcnt  <= '0;
                end
                ST_WARM: if (wcnt == term) state <= ST_RUN;
                         else wcnt <= wcnt + 1'b1;
                default: state <= ST_RUN;
            endcase
        end
    end

    p_warm_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WARM && wcnt == term) |=> ready);

    p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !wake_evt) |=> (state == ST_STOP));

    p_stop_in_warm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WARM && stop_req) |=> (state != ST_STOP));

endmodule

// File: rtl/sc_divider.sv
// System clock enable generator. Main codes 0..DIV_W-1 divide by
// 2^(DIV_W-code); code 111 emits on every second sub_tick. Counters
// are held at zero while not running.
module sc_divider #(
    parameter int DIV_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    input  logic       sub_tick,
    output logic       sys_en
);
    import sysclk_pkg::*;

    logic [DIV_W-1:0] dcnt;
    logic [DIV_W-1:0] lim;
    logic             sub_tog;
    logic             is_sub;

    // Last count of the main-clock period
    always_comb begin
        is_sub = (sel == SEL_SUB);
        lim    = is_sub ? '0 : DIV_W'((1 << (DIV_W - int'(sel))) - 1);
        sys_en = run && (is_sub ? (sub_tick && sub_tog) : (dcnt == lim));
    end

    // Free-running counters, cleared outside the running state
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            dcnt    <= '0;
            sub_tog <= 1'b0;
        end else begin
            dcnt <= (dcnt == lim) ? '0 : dcnt + 1'b1;
            if (sub_tick) sub_tog <= !sub_tog;
        end
    end

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_en && !is_sub && $stable(sel)) |=> !sys_en);

    p_sub_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_en && is_sub) |-> sub_tick);

endmodule

// File: rtl/sysclk_ctrl.sv
// Top of the system clock change controller. Holds the active rate,
// which is loaded from the control register only on a committed STOP.
module sysclk_ctrl #(
    parameter int WU_BASE = 15,
    parameter int DIV_W   = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       sub_tick,
    input  logic       stop_req,
    input  logic       wake_evt,
    output logic       sys_en,
    output logic       ready,
    output logic       main_osc_en
);
    import sysclk_pkg::*;

    logic [7:0] ctrl_q;
    logic [2:0] act_sel;
    logic       commit;
    sc_state_e  state;

    sc_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_q)
    );

    sc_warmup #(.WU_BASE(WU_BASE)) u_warm (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_evt(wake_evt),
        .chg_en(ctrl_q[7]), .wu_code(ctrl_q[1:0]), .state(state),
        .commit(commit), .ready(ready)
    );

    sc_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(ready), .sel(act_sel),
        .sub_tick(sub_tick), .sys_en(sys_en)
    );

    // Active rate, loaded on a committed STOP
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_sel <= 3'b000;
        else if (commit)
            act_sel <= ctrl_q[5:3];
    end

    // Read-back and oscillator enable
    always_comb begin
        rd_data     = ctrl_q;
        main_osc_en = !(ctrl_q[6] && act_sel == SEL_SUB);
    end

    p_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !ctrl_q[7]) |=> $stable(act_sel));

    p_quiet_when_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !sys_en);

    p_stop_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && stop_req) |=> !ready);

    p_osc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[6] && act_sel == SEL_SUB) |-> !main_osc_en);

endmodule

// File: tb/tb_sysclk_ctrl.sv
module tb_sysclk_ctrl;
    localparam int WB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sub_tick = 1'b0;
    logic       stop_req = 1'b0;
    logic       wake_evt = 1'b0;
    logic       sys_en, ready, main_osc_en;
    logic       sub_on = 1'b0;
    int         sub_ph = 0;
    int         errors = 0;
    int         checks = 0;
    int         cycles = 0;

    sysclk_ctrl #(.WU_BASE(WB), .DIV_W(5)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .sub_tick(sub_tick), .stop_req(stop_req), .wake_evt(wake_evt),
        .sys_en(sys_en), .ready(ready), .main_osc_en(main_osc_en)
    );

    always #4 clk = ~clk;

    // Sub-clock strobe: one cycle high every three
    always @(negedge clk) begin
        if (sub_on) begin
            sub_ph   <= (sub_ph == 2) ? 0 : sub_ph + 1;
            sub_tick <= (sub_ph == 2);
        end else begin
            sub_tick <= 1'b0;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_stop();
        stop_req = 1'b1;
        step();
        stop_req = 1'b0;
    endtask

    // Wake and return samples until ready (expected L+1)
    task automatic wake_count(output int k);
        wake_evt = 1'b1;
        step();
        wake_evt = 1'b0;
        k = 1;
        while (!ready && k < 5000) begin
            step();
            k++;
        end
    endtask

    // Samples until the next sys_en pulse
    task automatic to_pulse(output int k);
        k = 0;
        do begin
            step();
            k++;
        end while (!sys_en && k < 200);
    endtask

    // Full stop/wake with warm code 3, then check first pulse and period
    task automatic run_rate(input string req, input int n);
        int k;
        do_stop();
        wake_count(k);
        chk("R8", k, 17);
        to_pulse(k);
        chk({req, " first (R10)"}, k, n - 1);
        to_pulse(k);
        chk({req, " period"}, k, n);
        to_pulse(k);
        chk({req, " period"}, k, n);
    endtask

    task automatic t_reset();
        chk("R1 rd_data", rd_data, 0);
        chk("R1 ready", ready, 1);
        chk("R1 sys_en", sys_en, 0);
        chk("R1 main_osc_en", main_osc_en, 1);
    endtask

    task automatic t_regs();
        wr(8'h5F);
        chk("R2 bit2 masked", rd_data, 8'h5B);
        wr(8'h00);
        wr(8'hA8);
        chk("R3 code 101 kept old", rd_data, 8'h80);
        wr(8'h98);
        chk("R2 write", rd_data, 8'h98);
        wr(8'hB0);
        chk("R3 code 110 kept old", rd_data, 8'h98);
    endtask

    task automatic t_no_commit();
        wr(8'h23);
        do_stop();
        chk("R7 ready low in stop", ready, 0);
        repeat (5) begin
            step();
            chk("R7 no sys_en in stop", sys_en, 0);
        end
        run_rate("R6 divider unchanged", 32);
    endtask

    task automatic t_rates();
        for (int c = 0; c < 5; c++) begin
            wr(8'h80 | 8'(c << 3) | 8'h03);
            run_rate("R4", 32 >> c);
        end
    endtask

    task automatic t_warm_codes();
        int k;
        for (int c = 0; c < 3; c++) begin
            wr(8'h80 | 8'h20 | 8'(c));
            do_stop();
            wake_count(k);
            chk("R8 warm length", k, (1 << (WB + 3 - c)) + 1);
        end
    endtask

    task automatic t_idle_wake();
        int k;
        wake_evt = 1'b1;
        step();
        wake_evt = 1'b0;
        step();
        chk("R7 idle wake ready", ready, 1);
        to_pulse(k);
        to_pulse(k);
        chk("R7 idle wake period", k, 4);
    endtask

    task automatic t_stop_in_warm();
        int k;
        wr(8'h83 | 8'h18);
        do_stop();
        wake_evt = 1'b1;
        step();
        wake_evt = 1'b0;
        step();
        stop_req = 1'b1;
        step();
        stop_req = 1'b0;
        k = 3;
        while (!ready && k < 5000) begin
            step();
            k++;
        end
        chk("R9 warm not restarted", k, 17);
    endtask

    task automatic t_sub();
        int k, ticks, pulses, bad;
        wr(8'h43);
        chk("R11 main active, osc on", main_osc_en, 1);
        sub_on = 1'b1;
        wr(8'hFB);
        do_stop();
        wake_count(k);
        chk("R8 sub warm", k, 17);
        chk("R11 osc off", main_osc_en, 0);
        ticks = 0; pulses = 0; bad = 0;
        for (int i = 0; i < 60; i++) begin
            if (sub_tick) ticks++;
            if (sys_en) pulses++;
            if (sys_en && !sub_tick) bad++;
            step();
        end
        chk("R5 pulses per two ticks", pulses, ticks / 2);
        chk("R5 pulse only with tick", bad, 0);
        wr(8'hC3);
        chk("R11 pending main, osc stays off", main_osc_en, 0);
        wr(8'h83);
        chk("R11 bit6 clear, osc on", main_osc_en, 1);
        sub_on = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_regs();
        t_no_commit();
        t_rates();
        t_warm_codes();
        wr(8'h9B);
        run_rate("R4 div4", 4);
        t_idle_wake();
        t_stop_in_warm();
        t_sub();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule